// File: doc/BRIEF.md
# Per-Processor Interrupt Priority Presenter

This block sits in front of one processor and decides which single interrupt source, if any, is presented to it. It keeps five pieces of state: the processor's current priority threshold, the priority of a software-requested inter-processor interrupt, the number of the source now pending, that source's priority, and a flag recording that some offer was turned away. Smaller priority numbers are more urgent. The value 0x00 masks everything and 0xFF admits everything.

The source side offers interrupts, and the processor side reads, acknowledges and retunes them. All of this goes through one command port that takes at most one command per cycle. Every command carries a 32-bit data word. Offers and end-of-interrupt words carry a priority in bits 31:24 and a source number in bits 23:0. Threshold and inter-processor-priority writes carry their value in bits 7:0.

A pending source that loses its place is never dropped: it is sent back to the source side as a one-cycle reject pulse so that it can be offered again. A turned-away offer is remembered, and a resend-request pulse is raised once the processor becomes less selective. A level output tells the processor that an interrupt is waiting.

Top module: `irq_presenter`

## Requirements
- R1: `irq_out` is high exactly when the pending source number is non-zero and the pending priority is numerically lower than the current threshold. It never stays high in the cycle after an accept read.
- R2: An offer (op 0) with priority p succeeds only if the threshold, the IPI priority and the pending priority are all strictly above p. On success, `rsp_ok` is 1 and the offered source becomes pending at priority p. The source that was pending before is handed to the reject path.
- R3: A failed offer leaves the pending source, the pending priority and the threshold unchanged, and sets the resend-needed flag.
- R4: An accept read (op 1) returns the threshold in bits 31:24 and the pending source in bits 23:0. If a source was pending, the threshold takes the pending priority, the pending priority becomes 0xFF and the pending source is cleared.
- R5: An accept read with no pending source changes no state.
- R6: A threshold write (op 2) with a value above the current threshold loads it. If the IPI priority is below the new threshold and at or below the pending priority, source number IPI_SRC becomes pending at the IPI priority. A set resend-needed flag turns into a `resend_req` pulse and is cleared.
- R7: A threshold write equal to the current threshold has no effect.
- R8: A threshold write below the current threshold loads it. If the new value is at or below the pending priority, the pending source is rejected and cleared, and the pending priority becomes 0xFF.
- R9: An IPI priority write (op 3) loads the value. If the value is below the threshold and at or below the pending priority, the pending source is rejected and IPI_SRC becomes pending at that priority.
- R10: An IPI priority write that raises the value numerically turns a set resend-needed flag into a `resend_req` pulse and clears the flag.
- R11: An end-of-interrupt write (op 4) applies the lowering rule of R6 with the threshold from bits 31:24. It forwards bits 23:0 on `eoi_valid`/`eoi_src` unless they equal IPI_SRC.
- R12: `reject_valid` never carries source 0 or IPI_SRC. Such displaced values are dropped silently.
- R13: After reset the threshold is 0x00, the IPI priority is 0xFF, the pending priority is 0xFF, no source is pending and the resend-needed flag is clear. `cmd_ready` is low while reset is held.
- R14: A command is taken when `cmd_valid` and `cmd_ready` are both high. Op codes 5 to 7, and cycles without a taken command, change nothing and raise no pulse. Responses and pulses appear in the cycle after the command is taken and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Command code (0 offer, 1 accept, 2 threshold, 3 IPI priority, 4 EOI) |
| cmd_data | input | 32 | Command data word |
| rsp_valid | output | 1 | Response to an offer or an accept read |
| rsp_data | output | 32 | Packed word returned by an accept read |
| rsp_ok | output | 1 | Offer succeeded |
| irq_out | output | 1 | Interrupt waiting for the processor |
| reject_valid | output | 1 | Displaced source to redeliver |
| reject_src | output | 24 | Displaced source number |
| resend_req | output | 1 | Request to re-offer turned-away sources |
| eoi_valid | output | 1 | End-of-interrupt forwarded to the source side |
| eoi_src | output | 24 | Source number being completed |

## Verification
The assertions check state relations on every cycle. After a failed offer the resend flag is set. After a successful offer the offered source is pending. An accept read moves the pending priority into the threshold. An equal threshold write leaves the state frozen. An IPI priority write loads its value. Reject pulses never carry 0 or the IPI number, and EOIs for the IPI number are suppressed. Only the bench's command sequences can show the chained outcomes: an IPI made pending by lowering the threshold, a resend raised only by an IPI priority increase, and a displaced source reported with the right number.

// File: rtl/icp_pkg.sv
package icp_pkg;
    typedef enum logic [2:0] {
        OP_OFFER  = 3'd0,
        OP_ACCEPT = 3'd1,
        OP_THRESH = 3'd2,
        OP_IPIPRI = 3'd3,
        OP_EOI    = 3'd4
    } icp_op_e;
endpackage

// File: rtl/icp_cmd_decode.sv
module icp_cmd_decode
    import icp_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24,
    localparam int WORD_W = PRIO_W + SRC_W
) (
    input  logic              cmd_valid,
    input  logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              take,
    output icp_op_e           op,
    output logic [PRIO_W-1:0] level,
    output logic [SRC_W-1:0]  src
);
    logic known;

    always_comb begin
        known = 1'b1;
        op    = OP_OFFER;
        case (cmd_op)
            3'd0:    op = OP_OFFER;
            3'd1:    op = OP_ACCEPT;
            3'd2:    op = OP_THRESH;
            3'd3:    op = OP_IPIPRI;
            3'd4:    op = OP_EOI;
            default: known = 1'b0;
        endcase
        take = cmd_valid && cmd_ready && known;
        src  = cmd_data[SRC_W-1:0];
        // offers and EOIs carry the level in the top field, writes in the low field
        if (op == OP_THRESH || op == OP_IPIPRI)
            level = cmd_data[PRIO_W-1:0];
        else
            level = cmd_data[WORD_W-1:SRC_W];
    end
endmodule

// File: rtl/icp_state_core.sv
module icp_state_core
    import icp_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2,
    localparam int WORD_W = PRIO_W + SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  icp_op_e           op,
    input  logic [PRIO_W-1:0] level,
    input  logic [SRC_W-1:0]  src,
    output logic [PRIO_W-1:0] cppr_o,
    output logic [PRIO_W-1:0] pend_o,
    output logic [SRC_W-1:0]  xisr_o,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_ok,
    output logic              reject_valid,
    output logic [SRC_W-1:0]  reject_src,
    output logic              resend_req,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src
);
    localparam logic [SRC_W-1:0]  IPI_ID   = SRC_W'(IPI_SRC);
    localparam logic [PRIO_W-1:0] LEAST    = '1;

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [PRIO_W-1:0] mfrr;
        logic [PRIO_W-1:0] pend;
        logic [SRC_W-1:0]  xisr;
        logic              need;
    } icp_st_t;

    typedef struct packed {
        icp_st_t           st;
        logic              rsp_v;
        logic [WORD_W-1:0] rsp_w;
        logic              ok;
        logic              rej_v;
        logic [SRC_W-1:0]  rej_s;
        logic              resend;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_s;
    } icp_nx_t;

    icp_nx_t nx_d, nx_q;
    icp_st_t down_st;
    logic    down_resend;
    logic    offer_fits;
    logic [SRC_W-1:0] displaced;

    // shared lowering path used by threshold writes and EOIs
    always_comb begin
        down_st      = nx_q.st;
        down_st.cppr = level;
        if (nx_q.st.mfrr < level && nx_q.st.mfrr <= nx_q.st.pend) begin
            down_st.pend = nx_q.st.mfrr;
            down_st.xisr = IPI_ID;
        end
        down_resend  = nx_q.st.need;
        down_st.need = 1'b0;
    end

    always_comb begin
        offer_fits = (nx_q.st.cppr > level) && (nx_q.st.mfrr > level) &&
                     (nx_q.st.pend > level);
    end

    always_comb begin
        nx_d        = '0;
        nx_d.st     = nx_q.st;
        displaced   = '0;
        if (take) begin
            case (op)
                OP_OFFER: begin
                    nx_d.rsp_v = 1'b1;
                    if (offer_fits) begin
                        nx_d.ok      = 1'b1;
                        displaced    = nx_q.st.xisr;
                        nx_d.st.xisr = src;
                        nx_d.st.pend = level;
                    end else begin
                        nx_d.st.need = 1'b1;
                    end
                end
                OP_ACCEPT: begin
                    nx_d.rsp_v = 1'b1;
                    nx_d.rsp_w = {nx_q.st.cppr, nx_q.st.xisr};
                    if (nx_q.st.xisr != '0) begin
                        nx_d.st.cppr = nx_q.st.pend;
                        nx_d.st.pend = LEAST;
                        nx_d.st.xisr = '0;
                    end
                end
                OP_THRESH: begin
                    if (level > nx_q.st.cppr) begin
                        nx_d.st     = down_st;
                        nx_d.resend = down_resend;
                    end else if (level < nx_q.st.cppr) begin
                        nx_d.st.cppr = level;
                        if (level <= nx_q.st.pend) begin
                            displaced    = nx_q.st.xisr;
                            nx_d.st.xisr = '0;
                            nx_d.st.pend = LEAST;
                        end
                    end
                end
                OP_IPIPRI: begin
                    nx_d.st.mfrr = level;
                    if (level < nx_q.st.cppr && level <= nx_q.st.pend) begin
                        displaced    = nx_q.st.xisr;
                        nx_d.st.pend = level;
                        nx_d.st.xisr = IPI_ID;
                    end
                    if (level > nx_q.st.mfrr) begin
                        nx_d.resend  = nx_q.st.need;
                        nx_d.st.need = 1'b0;
                    end
                end
                OP_EOI: begin
                    nx_d.st     = down_st;
                    nx_d.resend = down_resend;
                    nx_d.eoi_v  = (src != IPI_ID);
                    nx_d.eoi_s  = (src != IPI_ID) ? src : '0;
                end
                default: ;
            endcase
        end
        nx_d.rej_v = (displaced != '0) && (displaced != IPI_ID);
        nx_d.rej_s = nx_d.rej_v ? displaced : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nx_q         <= '0;
            nx_q.st.cppr <= '0;
            nx_q.st.mfrr <= LEAST;
            nx_q.st.pend <= LEAST;
            nx_q.st.xisr <= '0;
            nx_q.st.need <= 1'b0;
        end else begin
            nx_q <= nx_d;
        end
    end

    assign cppr_o       = nx_q.st.cppr;
    assign pend_o       = nx_q.st.pend;
    assign xisr_o       = nx_q.st.xisr;
    assign rsp_valid    = nx_q.rsp_v;
    assign rsp_data     = nx_q.rsp_w;
    assign rsp_ok       = nx_q.ok;
    assign reject_valid = nx_q.rej_v;
    assign reject_src   = nx_q.rej_s;
    assign resend_req   = nx_q.resend;
    assign eoi_valid    = nx_q.eoi_v;
    assign eoi_src      = nx_q.eoi_s;

    // R2: a successful offer leaves the offered source pending
    a_r2_offer_loads: assert property (@(posedge clk) disable iff (!rst_n)
        take && op == OP_OFFER |=> (!nx_q.ok || nx_q.st.xisr == $past(src)));

    // R3: a refused offer sets the resend-needed flag
    a_r3_refusal_remembered: assert property (@(posedge clk) disable iff (!rst_n)
        take && op == OP_OFFER && !offer_fits |=> nx_q.st.need && !nx_q.ok);

    // R4: accept moves the pending priority into the threshold
    a_r4_accept_moves: assert property (@(posedge clk) disable iff (!rst_n)
        take && op == OP_ACCEPT && nx_q.st.xisr != '0 |=>
        nx_q.st.xisr == '0 && nx_q.st.pend == LEAST &&
        nx_q.st.cppr == $past(nx_q.st.pend));

    // R7: an equal threshold write freezes the state
    a_r7_equal_thresh_stable: assert property (@(posedge clk) disable iff (!rst_n)
        take && op == OP_THRESH && level == nx_q.st.cppr |=> $stable(nx_q.st));

    // R9: an IPI priority write always loads
    a_r9_ipi_prio_loads: assert property (@(posedge clk) disable iff (!rst_n)
        take && op == OP_IPIPRI |=> nx_q.st.mfrr == $past(level));

    // R11: the IPI number is never forwarded as an EOI
    a_r11_no_ipi_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        take && op == OP_EOI && src == IPI_ID |=> !nx_q.eoi_v);
endmodule

// File: rtl/icp_irq_gate.sv
module icp_irq_gate #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24
) (
    input  logic [PRIO_W-1:0] cppr,
    input  logic [PRIO_W-1:0] pend,
    input  logic [SRC_W-1:0]  xisr,
    output logic              irq
);
    always_comb begin
        irq = (xisr != '0) && (pend < cppr);
    end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import icp_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2,
    localparam int WORD_W = PRIO_W + SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_ok,
    output logic              irq_out,
    output logic              reject_valid,
    output logic [SRC_W-1:0]  reject_src,
    output logic              resend_req,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src
);
    logic              ready_d, ready_q;
    logic              take;
    icp_op_e           op;
    logic [PRIO_W-1:0] level;
    logic [SRC_W-1:0]  src;
    logic [PRIO_W-1:0] cppr, pend;
    logic [SRC_W-1:0]  xisr;

    always_comb ready_d = 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= ready_d;
    end

    assign cmd_ready = ready_q;

    icp_cmd_decode #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_ready (ready_q),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .take      (take),
        .op        (op),
        .level     (level),
        .src       (src)
    );

    icp_state_core #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .op           (op),
        .level        (level),
        .src          (src),
        .cppr_o       (cppr),
        .pend_o       (pend),
        .xisr_o       (xisr),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rsp_ok       (rsp_ok),
        .reject_valid (reject_valid),
        .reject_src   (reject_src),
        .resend_req   (resend_req),
        .eoi_valid    (eoi_valid),
        .eoi_src      (eoi_src)
    );

    icp_irq_gate #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_gate (
        .cppr (cppr),
        .pend (pend),
        .xisr (xisr),
        .irq  (irq_out)
    );

    // R1: the interrupt line is down right after an accept read
    a_r1_irq_drops_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        take && op == OP_ACCEPT |=> !irq_out);

    // R12: displaced zero or IPI numbers are never reported
    a_r12_reject_filtered: assert property (@(posedge clk) disable iff (!rst_n)
        reject_valid |-> reject_src != '0 && reject_src != SRC_W'(IPI_SRC));

    // R14: without a taken command nothing pulses
    a_r14_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !rsp_valid && !reject_valid && !resend_req && !eoi_valid);
endmodule

// File: tb/irq_presenter_bench.sv
module irq_presenter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] cmd_data = 32'd0;
    logic        rsp_valid, rsp_ok, irq_out, reject_valid, resend_req, eoi_valid;
    logic [31:0] rsp_data;
    logic [23:0] reject_src, eoi_src;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_presenter u_irq_presenter (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_op       (cmd_op),
        .cmd_data     (cmd_data),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rsp_ok       (rsp_ok),
        .irq_out      (irq_out),
        .reject_valid (reject_valid),
        .reject_src   (reject_src),
        .resend_req   (resend_req),
        .eoi_valid    (eoi_valid),
        .eoi_src      (eoi_src)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] data;
        logic [31:0] rsp;
        logic        ok;
        logic        rv;
        logic [23:0] rs;
        logic        rsd;
        logic        ev;
        logic [23:0] es;
        logic        irq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h05000010, 32'h0,        1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b0}, // R3 refused at threshold 0
        '{3'd2, 32'h000000FF, 32'h0,        1'b0, 1'b0, 24'h0,  1'b1, 1'b0, 24'h0,  1'b0}, // R6 lower, resend
        '{3'd0, 32'h05000010, 32'h0,        1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b1}, // R2 accepted
        '{3'd0, 32'h03000020, 32'h0,        1'b1, 1'b1, 24'h10, 1'b0, 1'b0, 24'h0,  1'b1}, // R2 displaces 0x10
        '{3'd0, 32'h04000030, 32'h0,        1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b1}, // R3 refused by pending
        '{3'd1, 32'h0,        32'hFF000020, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b0}, // R4
        '{3'd1, 32'h0,        32'h03000000, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b0}, // R5 empty accept
        '{3'd4, 32'hFF000020, 32'h0,        1'b0, 1'b0, 24'h0,  1'b1, 1'b1, 24'h20, 1'b0}, // R11 EOI with resend
        '{3'd3, 32'h00000006, 32'h0,        1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b1}, // R9 IPI pending, empty reject dropped
        '{3'd0, 32'h04000040, 32'h0,        1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b1}, // R12 IPI displaced silently
        '{3'd2, 32'h00000004, 32'h0,        1'b0, 1'b1, 24'h40, 1'b0, 1'b0, 24'h0,  1'b0}, // R8 raise rejects 0x40
        '{3'd2, 32'h00000004, 32'h0,        1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b0}, // R7 equal write
        '{3'd0, 32'h02000050, 32'h0,        1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b1}, // R2
        '{3'd3, 32'h00000001, 32'h0,        1'b0, 1'b1, 24'h50, 1'b0, 1'b0, 24'h0,  1'b1}, // R9 rejects 0x50
        '{3'd3, 32'h00000007, 32'h0,        1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b1}, // R10 increase, nothing owed
        '{3'd0, 32'h03000060, 32'h0,        1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b1}, // R3
        '{3'd3, 32'h00000009, 32'h0,        1'b0, 1'b0, 24'h0,  1'b1, 1'b0, 24'h0,  1'b1}, // R10 increase, resend
        '{3'd1, 32'h0,        32'h04000002, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b0}, // R4 IPI taken
        '{3'd4, 32'h04000002, 32'h0,        1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b0}, // R11 IPI EOI suppressed
        '{3'd2, 32'h000000FF, 32'h0,        1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b1}, // R6 IPI made pending
        '{3'd1, 32'h0,        32'hFF000002, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0,  1'b0}  // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, results are visible at the next falling edge
    task automatic issue(input logic [2:0] op, input logic [31:0] data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R13 ready low in reset", {31'd0, cmd_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R13 reset state seen at the ports
        check("R13 ready after reset", {31'd0, cmd_ready}, 32'd1);
        check("R13 irq low after reset", {31'd0, irq_out}, 32'd0);
        check("R14 no pulse after reset",
              {28'd0, rsp_valid, reject_valid, resend_req, eoi_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].data);
            check($sformatf("R14 rsp_valid v%0d", i), {31'd0, rsp_valid},
                  {31'd0, (VECS[i].op == 3'd0 || VECS[i].op == 3'd1)});
            if (VECS[i].op == 3'd1)
                check($sformatf("R4 accept word v%0d", i), rsp_data, VECS[i].rsp);
            if (VECS[i].op == 3'd0)
                check($sformatf("R2 offer ok v%0d", i), {31'd0, rsp_ok}, {31'd0, VECS[i].ok});
            check($sformatf("R12 reject_valid v%0d", i), {31'd0, reject_valid}, {31'd0, VECS[i].rv});
            if (VECS[i].rv)
                check($sformatf("R8 reject_src v%0d", i), {8'd0, reject_src}, {8'd0, VECS[i].rs});
            check($sformatf("R6 resend v%0d", i), {31'd0, resend_req}, {31'd0, VECS[i].rsd});
            check($sformatf("R11 eoi_valid v%0d", i), {31'd0, eoi_valid}, {31'd0, VECS[i].ev});
            if (VECS[i].ev)
                check($sformatf("R11 eoi_src v%0d", i), {8'd0, eoi_src}, {8'd0, VECS[i].es});
            check($sformatf("R1 irq v%0d", i), {31'd0, irq_out}, {31'd0, VECS[i].irq});
        end

        // R14 pulses last a single cycle
        issue(3'd0, 32'h01000070);
        check("R2 offer at threshold 9 ok", {31'd0, rsp_ok}, 32'd1);
        @(negedge clk);
        check("R14 pulses gone next cycle",
              {28'd0, rsp_valid, reject_valid, resend_req, eoi_valid}, 32'd0);

        // R14 unused op code changes nothing
        issue(3'd6, 32'h00000000);
        check("R14 unused op no response", {31'd0, rsp_valid}, 32'd0);
        // R14 data with valid low is ignored
        @(negedge clk);
        cmd_op = 3'd2;
        cmd_data = 32'h00000000;
        @(negedge clk);
        check("R14 idle no pulse", {29'd0, rsp_valid, reject_valid, eoi_valid}, 32'd0);
        issue(3'd1, 32'h0);
        check("R14 state untouched by ignored cmds", rsp_data, 32'h09000070);

        // R13 a mid-run reset restores the reset state
        do_reset();
        issue(3'd1, 32'h0);
        check("R13 threshold 0 and empty after reset", rsp_data, 32'h00000000);
        issue(3'd0, 32'h05000011);
        check("R13 all masked after reset", {31'd0, rsp_ok}, 32'd0);
        issue(3'd2, 32'h000000FF);
        check("R13 resend owed after refusal", {31'd0, resend_req}, 32'd1);
        check("R13 IPI priority FF leaves nothing pending", {31'd0, irq_out}, 32'd0);
        issue(3'd1, 32'h0);
        check("R13 accept after reset lowering", rsp_data, 32'hFF000000);

        finish_run();
    end
endmodule